// File: doc/BRIEF.md
# Packed Lane Shuffle Network

This block is a purely combinational permutation unit for packed SIMD data. It takes two 64-bit source vectors, `vs` and `vt`, and a 5-bit shuffle code, and forms a 64-bit result by routing whole lanes from the two sources into fixed positions. In byte mode the result has eight 8-bit lanes. In halfword mode it has four 16-bit lanes.

The code selects both the lane format and one pattern from a fixed set. The set covers:

- interleaving the upper or lower halves of the two sources;
- packing the odd or even lanes;
- a halfword butterfly swap;
- two halfword replicate forms;
- a byte unpack that pairs each low `vs` byte with its sign-extension byte.

Codes that name no pattern give an all-zero result and raise a flag, which the surrounding pipeline uses to report an illegal operation. The block has no state and no clock. Operand fetch, instruction decode and write-back sit around it.

Top module: `lane_shuffle_unit`

## Requirements
- R1: The mode is decoded from the low code bits. code[1:0]=01 selects halfword mode with pattern index code[4:2]. code[0]=0 selects byte mode with pattern index code[4:1]. code[1:0]=11 is reserved.
- R2: Halfword index 0 (mix-high) gives lanes {vt2, vs2, vt3, vs3} from output lane 0 upward. Index 1 (mix-low) gives {vt0, vs0, vt1, vs1}.
- R3: Halfword index 2 (pack-high) gives {vt1, vt3, vs1, vs3}.
- R4: Halfword index 4 (butterfly) gives {vt1, vs0, vt3, vs2}.
- R5: Halfword index 6 (replicate-A) gives {vt2, vt3, vs2, vs3}. Index 7 (replicate-B) gives {vt0, vt1, vs0, vs1}.
- R6: Byte index 3 (unpack-low) gives {vs0, s0, vs1, s1, vs2, s2, vs3, s3}. Each sign byte sN is 0xFF when bit 7 of vs byte N is 1, and 0x00 otherwise.
- R7: Byte index 4 (pack-high) gives vt bytes 1,3,5,7 followed by vs bytes 1,3,5,7. Byte index 5 (pack-low) gives vt bytes 0,2,4,6 followed by vs bytes 0,2,4,6.
- R8: Byte indices 6 and 1 (mix-high) give {vt4, vs4, vt5, vs5, vt6, vs6, vt7, vs7}. Byte indices 7 and 2 (mix-low) give {vt0, vs0, vt1, vs1, vt2, vs2, vt3, vs3}.
- R9: A reserved code drives the result to all zeros and sets `rsvdCode` to 1. The reserved codes are:
  - halfword indices 3 and 5;
  - byte index 0;
  - byte indices 8 to 15;
  - any code with low bits 11.
- R10: Every non-reserved code leaves `rsvdCode` at 0.
- R11: Output lane 0 occupies the least significant bits of `result`, and source lane N occupies bits [N*w+w-1 : N*w] for lane width w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shufCode | input | 5 | Shuffle code: format and pattern index |
| vs | input | 64 | First source vector |
| vt | input | 64 | Second source vector |
| result | output | 64 | Permuted vector |
| rsvdCode | output | 1 | High when the code is reserved or undefined |

## Verification
The bound checker evaluates on every input change:

- that reserved codes force a zero result;
- that any code with low bits 11 raises the flag;
- that lane 0 of halfword mix-low carries the low halfword of `vt`;
- that replicate-B copies the low half of `vt`;
- that the unpack-low sign byte follows bit 7 of `vs` byte 0.

The full lane routing of every pattern, the byte aliases at indices 1 and 2, and the upper reserved byte indices can only be shown by the bench. The bench sweeps all 32 codes against structured and random operand pairs and compares each result with a behavioural model.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;

  localparam int CODE_W = 5;

  typedef enum logic [3:0] {
    PAT_NONE,
    PAT_MIXH,
    PAT_MIXL,
    PAT_UNPK,
    PAT_PACKH,
    PAT_PACKL,
    PAT_BFLY,
    PAT_REPA,
    PAT_REPB
  } pattern_e;

  typedef enum logic [1:0] {
    SRC_VS,
    SRC_VT,
    SRC_SIGN,
    SRC_ZERO
  } source_e;

  // Strobes from the decoder to the lane datapath
  typedef struct packed {
    logic     halfMode;
    logic     reserved;
    pattern_e pattern;
  } shuf_ctrl_t;

endpackage

// File: rtl/lane_shuffle_ctrl.sv
module lane_shuffle_ctrl
  import lane_shuffle_pkg::*;
(
  input  logic [CODE_W-1:0] shufCode,
  output shuf_ctrl_t        ctrl
);

  logic [CODE_W-3:0] halfIdx;
  logic [CODE_W-2:0] byteIdx;

  assign halfIdx = shufCode[CODE_W-1:2];
  assign byteIdx = shufCode[CODE_W-1:1];

  always_comb begin
    ctrl.halfMode = 1'b0;
    ctrl.reserved = 1'b1;
    ctrl.pattern  = PAT_NONE;
    if (shufCode[1:0] == 2'b01) begin
      ctrl.halfMode = 1'b1;
      ctrl.reserved = 1'b0;
      case (halfIdx)
        3'd0:    ctrl.pattern = PAT_MIXH;
        3'd1:    ctrl.pattern = PAT_MIXL;
        3'd2:    ctrl.pattern = PAT_PACKH;
        3'd4:    ctrl.pattern = PAT_BFLY;
        3'd6:    ctrl.pattern = PAT_REPA;
        3'd7:    ctrl.pattern = PAT_REPB;
        default: ctrl.reserved = 1'b1;
      endcase
    end else if (shufCode[0] == 1'b0) begin
      ctrl.reserved = 1'b0;
      case (byteIdx)
        4'd1, 4'd6: ctrl.pattern = PAT_MIXH;
        4'd2, 4'd7: ctrl.pattern = PAT_MIXL;
        4'd3:       ctrl.pattern = PAT_UNPK;
        4'd4:       ctrl.pattern = PAT_PACKH;
        4'd5:       ctrl.pattern = PAT_PACKL;
        default:    ctrl.reserved = 1'b1;
      endcase
    end
    if (ctrl.reserved) ctrl.pattern = PAT_NONE;
  end

endmodule

// File: rtl/lane_shuffle_datapath.sv
module lane_shuffle_datapath
  import lane_shuffle_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] vs,
  input  logic [DATA_W-1:0] vt,
  input  shuf_ctrl_t        ctrl,
  output logic [DATA_W-1:0] result
);

  localparam int BYTE_LANES = DATA_W / BYTE_W;
  localparam int HALF_LANES = DATA_W / HALF_W;
  localparam int BIDX_W     = $clog2(BYTE_LANES);
  localparam int HIDX_W     = $clog2(HALF_LANES);
  localparam int BYTE_MID   = BYTE_LANES / 2;
  localparam int HALF_MID   = HALF_LANES / 2;

  logic [BYTE_W-1:0] vsByte [BYTE_LANES];
  logic [BYTE_W-1:0] vtByte [BYTE_LANES];
  logic [HALF_W-1:0] vsHalf [HALF_LANES];
  logic [HALF_W-1:0] vtHalf [HALF_LANES];
  logic [DATA_W-1:0] byteRes;
  logic [DATA_W-1:0] halfRes;

  genvar g;

  // Split the sources into lanes, lane 0 at the LSBs
  generate
    for (g = 0; g < BYTE_LANES; g++) begin : g_bsplit
      assign vsByte[g] = vs[g*BYTE_W +: BYTE_W];
      assign vtByte[g] = vt[g*BYTE_W +: BYTE_W];
    end
    for (g = 0; g < HALF_LANES; g++) begin : g_hsplit
      assign vsHalf[g] = vs[g*HALF_W +: HALF_W];
      assign vtHalf[g] = vt[g*HALF_W +: HALF_W];
    end
  endgenerate

  // Byte-mode lane routing
  generate
    for (g = 0; g < BYTE_LANES; g++) begin : g_blane
      localparam int MIXH_I  = BYTE_MID + g / 2;
      localparam int MIXL_I  = g / 2;
      localparam int PACKH_I = 2 * (g % BYTE_MID) + 1;
      localparam int PACKL_I = 2 * (g % BYTE_MID);
      localparam bit EVEN    = (g % 2) == 0;
      localparam bit LOWPART = g < BYTE_MID;

      source_e           src;
      logic [BIDX_W-1:0] idx;
      logic [BYTE_W-1:0] srcByte;

      always_comb begin
        src = SRC_ZERO;
        idx = '0;
        case (ctrl.pattern)
          PAT_MIXH: begin
            src = EVEN ? SRC_VT : SRC_VS;
            idx = BIDX_W'(MIXH_I);
          end
          PAT_MIXL: begin
            src = EVEN ? SRC_VT : SRC_VS;
            idx = BIDX_W'(MIXL_I);
          end
          PAT_UNPK: begin
            src = EVEN ? SRC_VS : SRC_SIGN;
            idx = BIDX_W'(MIXL_I);
          end
          PAT_PACKH: begin
            src = LOWPART ? SRC_VT : SRC_VS;
            idx = BIDX_W'(PACKH_I);
          end
          PAT_PACKL: begin
            src = LOWPART ? SRC_VT : SRC_VS;
            idx = BIDX_W'(PACKL_I);
          end
          default: begin
            src = SRC_ZERO;
            idx = '0;
          end
        endcase
      end

      always_comb begin
        case (src)
          SRC_VS:   srcByte = vsByte[idx];
          SRC_VT:   srcByte = vtByte[idx];
          SRC_SIGN: srcByte = {BYTE_W{vsByte[idx][BYTE_W-1]}};
          default:  srcByte = '0;
        endcase
      end

      assign byteRes[g*BYTE_W +: BYTE_W] = srcByte;
    end
  endgenerate

  // Halfword-mode lane routing
  generate
    for (g = 0; g < HALF_LANES; g++) begin : g_hlane
      localparam int MIXH_I  = HALF_MID + g / 2;
      localparam int MIXL_I  = g / 2;
      localparam int PACKH_I = 2 * (g % HALF_MID) + 1;
      localparam int REPA_I  = HALF_MID + (g % HALF_MID);
      localparam int REPB_I  = g % HALF_MID;
      localparam bit EVEN    = (g % 2) == 0;
      localparam bit LOWPART = g < HALF_MID;
      localparam int BFLY_I  = EVEN ? g + 1 : g - 1;

      source_e           src;
      logic [HIDX_W-1:0] idx;
      logic [HALF_W-1:0] srcHalf;

      always_comb begin
        src = SRC_ZERO;
        idx = '0;
        case (ctrl.pattern)
          PAT_MIXH: begin
            src = EVEN ? SRC_VT : SRC_VS;
            idx = HIDX_W'(MIXH_I);
          end
          PAT_MIXL: begin
            src = EVEN ? SRC_VT : SRC_VS;
            idx = HIDX_W'(MIXL_I);
          end
          PAT_PACKH: begin
            src = LOWPART ? SRC_VT : SRC_VS;
            idx = HIDX_W'(PACKH_I);
          end
          PAT_BFLY: begin
            src = EVEN ? SRC_VT : SRC_VS;
            idx = HIDX_W'(BFLY_I);
          end
          PAT_REPA: begin
            src = LOWPART ? SRC_VT : SRC_VS;
            idx = HIDX_W'(REPA_I);
          end
          PAT_REPB: begin
            src = LOWPART ? SRC_VT : SRC_VS;
            idx = HIDX_W'(REPB_I);
          end
          default: begin
            src = SRC_ZERO;
            idx = '0;
          end
        endcase
      end

      always_comb begin
        case (src)
          SRC_VS:  srcHalf = vsHalf[idx];
          SRC_VT:  srcHalf = vtHalf[idx];
          default: srcHalf = '0;
        endcase
      end

      assign halfRes[g*HALF_W +: HALF_W] = srcHalf;
    end
  endgenerate

  always_comb begin
    if (ctrl.reserved)      result = '0;
    else if (ctrl.halfMode) result = halfRes;
    else                    result = byteRes;
  end

endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lane_shuffle_pkg::*;
(
  input  logic [4:0]  shufCode,
  input  logic [63:0] vs,
  input  logic [63:0] vt,
  output logic [63:0] result,
  output logic        rsvdCode
);

  shuf_ctrl_t ctrl;

  lane_shuffle_ctrl u_ctrl (
    .shufCode (shufCode),
    .ctrl     (ctrl)
  );

  lane_shuffle_datapath #(
    .DATA_W (64),
    .BYTE_W (8),
    .HALF_W (16)
  ) u_dp (
    .vs     (vs),
    .vt     (vt),
    .ctrl   (ctrl),
    .result (result)
  );

  assign rsvdCode = ctrl.reserved;

endmodule

// File: rtl/lane_shuffle_chk.sv
module lane_shuffle_chk (
  input logic [4:0]  shufCode,
  input logic [63:0] vs,
  input logic [63:0] vt,
  input logic [63:0] result,
  input logic        rsvdCode
);

  always_comb begin
    if (!$isunknown({shufCode, vs, vt, result, rsvdCode})) begin
      // R9
      rsvd_zero_chk: assert (!rsvdCode || result == 64'd0)
        else $error("reserved code gave non-zero result");
      // R1
      undef_low_bits_chk: assert (shufCode[1:0] != 2'b11 || rsvdCode)
        else $error("low bits 11 not flagged");
      // R2
      half_mixl_lane0_chk: assert (shufCode != 5'b00101 || result[15:0] == vt[15:0])
        else $error("halfword mix-low lane 0 wrong");
      // R5
      half_repb_chk: assert (shufCode != 5'b11101 || result[31:0] == vt[31:0])
        else $error("replicate-B low half wrong");
      // R6
      byte_unpk_sign_chk: assert (shufCode != 5'b00110 || result[15:8] == {8{vs[7]}})
        else $error("unpack-low sign byte wrong");
    end
  end

endmodule

bind lane_shuffle_unit lane_shuffle_chk u_chk (
  .shufCode (shufCode),
  .vs       (vs),
  .vt       (vt),
  .result   (result),
  .rsvdCode (rsvdCode)
);

// File: tb/sim_lane_shuffle_unit.sv
module sim_lane_shuffle_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [4:0]  shufCode = 5'd0;
  logic [63:0] vs = 64'd0;
  logic [63:0] vt = 64'd0;
  logic [63:0] result;
  logic        rsvdCode;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_shuffle_unit u0 (
    .shufCode (shufCode),
    .vs       (vs),
    .vt       (vt),
    .result   (result),
    .rsvdCode (rsvdCode)
  );

  function automatic logic [7:0] bsel(input logic [63:0] v, input int i);
    return v[i*8 +: 8];
  endfunction

  function automatic logic [15:0] hsel(input logic [63:0] v, input int i);
    return v[i*16 +: 16];
  endfunction

  // Behavioural reference: each pattern written as its lane list
  function automatic void model(input logic [4:0] c, input logic [63:0] a,
                                input logic [63:0] b, output logic [63:0] r,
                                output bit rsv);
    logic [15:0] h[4];
    logic [7:0]  y[8];
    int idx;
    r = 64'd0;
    rsv = 0;
    if (c[1:0] == 2'b01) begin
      idx = c >> 2;
      case (idx)
        0: h = '{hsel(b,2), hsel(a,2), hsel(b,3), hsel(a,3)};
        1: h = '{hsel(b,0), hsel(a,0), hsel(b,1), hsel(a,1)};
        2: h = '{hsel(b,1), hsel(b,3), hsel(a,1), hsel(a,3)};
        4: h = '{hsel(b,1), hsel(a,0), hsel(b,3), hsel(a,2)};
        6: h = '{hsel(b,2), hsel(b,3), hsel(a,2), hsel(a,3)};
        7: h = '{hsel(b,0), hsel(b,1), hsel(a,0), hsel(a,1)};
        default: rsv = 1;
      endcase
      if (!rsv) r = {h[3], h[2], h[1], h[0]};
    end else if (c[0] == 1'b0) begin
      idx = c >> 1;
      case (idx)
        1, 6: y = '{bsel(b,4), bsel(a,4), bsel(b,5), bsel(a,5),
                    bsel(b,6), bsel(a,6), bsel(b,7), bsel(a,7)};
        2, 7: y = '{bsel(b,0), bsel(a,0), bsel(b,1), bsel(a,1),
                    bsel(b,2), bsel(a,2), bsel(b,3), bsel(a,3)};
        3: for (int k = 0; k < 4; k++) begin
             y[2*k]   = bsel(a,k);
             y[2*k+1] = bsel(a,k)[7] ? 8'hFF : 8'h00;
           end
        4: y = '{bsel(b,1), bsel(b,3), bsel(b,5), bsel(b,7),
                 bsel(a,1), bsel(a,3), bsel(a,5), bsel(a,7)};
        5: y = '{bsel(b,0), bsel(b,2), bsel(b,4), bsel(b,6),
                 bsel(a,0), bsel(a,2), bsel(a,4), bsel(a,6)};
        default: rsv = 1;
      endcase
      if (!rsv) for (int k = 0; k < 8; k++) r[k*8 +: 8] = y[k];
    end else begin
      rsv = 1;
    end
  endfunction

  function automatic string reqOf(input logic [4:0] c);
    int i;
    if (c[1:0] == 2'b11) return "R1/R9";
    if (c[1:0] == 2'b01) begin
      i = c >> 2;
      case (i)
        0, 1: return "R2";
        2: return "R3";
        4: return "R4";
        6, 7: return "R5";
        default: return "R9";
      endcase
    end
    i = c >> 1;
    case (i)
      3: return "R6";
      4, 5: return "R7";
      1, 2, 6, 7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic runOne(input logic [4:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    bit ers;
    @(posedge clk);
    #1;
    shufCode = c;
    vs = a;
    vt = b;
    @(negedge clk);
    model(c, a, b, er, ers);
    compared++;
    if (result !== er) begin
      mismatched++;
      $display("FAIL %s code=%0d result actual=%h expected=%h", reqOf(c), c, result, er);
    end
    compared++;
    if (rsvdCode !== ers) begin
      mismatched++;
      $display("FAIL %s code=%0d rsvdCode actual=%b expected=%b",
               ers ? "R9" : "R10", c, rsvdCode, ers);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa, pb;
    // Reset state: code 0 is reserved byte index 0 (R9)
    @(negedge clk);
    compared++;
    if (result !== 64'd0 || rsvdCode !== 1'b1) begin
      mismatched++;
      $display("FAIL R9 reset result actual=%h/%b expected=0/1", result, rsvdCode);
    end
    // R11: distinct lane values expose ordering across all codes
    for (int c = 0; c < 32; c++)
      runOne(5'(c), 64'h8F7E_6D5C_4B3A_2918, 64'h0716_2534_4352_6170);
    for (int c = 0; c < 32; c++)
      runOne(5'(c), 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int c = 0; c < 32; c++)
      runOne(5'(c), 64'h80FF_7F01_8000_7FFF, 64'h1234_5678_9ABC_DEF0);
    // R6: sign bytes at each boundary value
    runOne(5'b00110, 64'h0000_0000_807F_FF00, 64'd0);
    runOne(5'b00110, 64'h0000_0000_0180_7FFF, 64'd0);
    // R11: halfword mix-low lane 0 at LSBs
    runOne(5'b00101, 64'd0, 64'h0000_0000_0000_BEEF);
    // Random sweep
    for (int n = 0; n < 3000; n++) begin
      pa = {$urandom, $urandom};
      pb = {$urandom, $urandom};
      runOne(5'($urandom_range(0, 31)), pa, pb);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule